// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block is a management-interface master for external PHY devices. Software controls it through two 32-bit registers: a command register and a data register. A transaction starts when software writes the data register, then writes the command register with its busy bit set. The block then produces the management clock from the system clock with a selectable divider. It serialises one frame (Clause 22) or two frames (Clause 45) on the data line, using a tri-state output enable. When the transaction ends it clears busy. After a read, the low halfword of the data register holds the value returned by the PHY.

Bit positions that other logic decodes are fixed:
- Command register: busy in bit 0, the Clause 45 enable or legacy write flag in bit 1, the operation code in [3:2], the clock select in [11:8], the register number or device address in [20:16], and the PHY address in [25:21].
- Data register: write data in [15:0]. For a Clause 45 access, the register address is in [31:16].

A build parameter chooses between two command decodings. The default two-bit operation code also allows Clause 45 accesses. The legacy single-bit flag allows only Clause 22 accesses.

Top module: `mdio_csr_master`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the MDIO output enable is low.
- R2: A command-register write with bit 0 set and an accepted operation starts a transaction. Bit 0 reads 1 until the final frame has ended and then reads 0. All other command bits keep the value written.
- R3: A Clause 22 frame is sent MSB-first as 64 bits: 32 ones, then start 01, then op (01 write, 10 read), then the 5-bit PHY address, then the 5-bit register number. A write frame follows these with turnaround 10 and the 16 data bits from data[15:0].
- R4: With OP_MODE=0, command bits [3:2] = 01 select a write and 11 select a read. A write of the command register that has bit 0 set and code 00 or 10 is ignored entirely: the register keeps its old value, and no frame is sent.
- R5: With OP_MODE=1, command bit 1 set selects a write and clear selects a read. The access is always Clause 22.
- R6: With OP_MODE=0 and command bit 1 set, a Clause 45 transaction sends two frames while busy stays set. The first is an address frame: start 00, op 00, the PHY address, then the device address taken from [20:16], then turnaround 10, then data[31:16]. The second frame uses start 00 and op 01 for a write with data[15:0], or op 11 for a read.
- R7: In a read frame the output enable is low for bits 46 to 63 (turnaround and data). MDIO input is sampled on MDC rising edges, MSB first. At completion, data[15:0] holds the sampled word and data[31:16] is unchanged.
- R8: MDC is low whenever busy is clear. While a frame runs, MDC has a 50% duty cycle and a period of 16 << min(sel,3) system clocks, where sel is command [11:8].
- R9: The driven MDIO value changes only on falling MDC edges. It is stable while MDC is high.
- R10: While busy is set, writes to either register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe, one cycle per write |
| csr_sel_data | input | 1 | Write target: 0 command register, 1 data register |
| csr_wdata | input | 32 | Register write value |
| csr_cmd_rd | output | 32 | Current command register contents |
| csr_data_rd | output | 32 | Current data register contents |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the pad |
| mdio_o | output | 1 | Management data to the pad |
| mdio_oe | output | 1 | Pad output enable, high drives MDIO |

## Verification
The assertions assume three things about the inputs. Software issues a register write only as a single-cycle strobe. It loads the data register before it sets busy. The PHY moves mdio_i only while MDC is low, so each rising-edge sample sees a settled value. The bench keeps to these: it writes through a task that raises csr_we for exactly one cycle, it orders each data write before the command write, and its PHY model changes mdio_i only on falling MDC edges. Writes that arrive during busy are applied on purpose, to show that they have no effect.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = 6;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int SEL_W      = 4;

  localparam int CMD_BUSY  = 0;
  localparam int CMD_FLAG  = 1;
  localparam int CMD_OP    = 2;
  localparam int CMD_SEL   = 8;
  localparam int CMD_REG   = 16;
  localparam int CMD_PHY   = 21;

  localparam logic [31:0] PREAMBLE = 32'hFFFF_FFFF;
  localparam logic [1:0]  ST_C22   = 2'b01;
  localparam logic [1:0]  ST_C45   = 2'b00;
  localparam logic [1:0]  OPF_ADDR = 2'b00;
  localparam logic [1:0]  OPF_WR   = 2'b01;
  localparam logic [1:0]  OPF_RD22 = 2'b10;
  localparam logic [1:0]  OPF_RD45 = 2'b11;
  localparam logic [1:0]  TA_DRIVE = 2'b10;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_XFER} phase_t;

  function automatic logic [FRAME_BITS-1:0] mk_frame(input logic [1:0] st,
                                                      input logic [1:0] op,
                                                      input logic [4:0] pa,
                                                      input logic [4:0] ra,
                                                      input logic [15:0] body);
    return {PREAMBLE, st, op, pa, ra, TA_DRIVE, body};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int SEL_W    = 4,
  parameter int MIN_LOG2 = 4,
  parameter int SEL_MAX  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int CNT_W = MIN_LOG2 + SEL_MAX - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             mdc_q, mdc_d, tick;
  int               sel_eff;

  always_comb begin
    sel_eff = (int'(sel) > SEL_MAX) ? SEL_MAX : int'(sel);
    half_m1 = CNT_W'((1 << (MIN_LOG2 - 1 + sel_eff)) - 1);
    tick    = run && (cnt_q == half_m1);
    rise    = tick && !mdc_q;
    fall    = tick && mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        c45,
  input  logic        is_read,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [31:0] payload,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_word
);
  phase_t                ph_q, ph_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           rd_q, rd_d;
  logic                  rd_frame, last_bit;

  always_comb begin
    rd_frame = (ph_q == PH_XFER) && is_read;
    last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));
    done     = (ph_q == PH_XFER) && fall && last_bit;
    ph_d     = ph_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    rd_d     = rd_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        bit_d = '0;
        if (c45) begin
          ph_d = PH_ADDR;
          sh_d = mk_frame(ST_C45, OPF_ADDR, phy, regad, payload[31:16]);
        end else begin
          ph_d = PH_XFER;
          sh_d = mk_frame(ST_C22, is_read ? OPF_RD22 : OPF_WR, phy, regad,
                          payload[15:0]);
        end
      end
    end else begin
      if (rise && rd_frame && (bit_q >= BIT_W'(DATA_POS)))
        rd_d = {rd_q[14:0], mdio_i};
      if (fall) begin
        if (last_bit) begin
          bit_d = '0;
          if (ph_q == PH_ADDR) begin
            ph_d = PH_XFER;
            sh_d = mk_frame(ST_C45, is_read ? OPF_RD45 : OPF_WR, phy, regad,
                            payload[15:0]);
          end else begin
            ph_d = PH_IDLE;
          end
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      rd_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      rd_q  <= rd_d;
    end
  end

  assign active  = (ph_q != PH_IDLE);
  assign mdio_o  = active && sh_q[FRAME_BITS-1];
  assign mdio_oe = active && !(rd_frame && (bit_q >= BIT_W'(TA_POS)));
  assign rd_word = rd_q;
endmodule

// File: rtl/mdio_csr_regs.sv
module mdio_csr_regs
  import mdio_pkg::*;
#(
  parameter int OP_MODE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        sel_data,
  input  logic [31:0] wdata,
  input  logic        done,
  input  logic [15:0] rd_word,
  output logic [31:0] cmd_q,
  output logic [31:0] data_q,
  output logic        start_q,
  output logic        c45,
  output logic        is_read
);
  logic [31:0] cmd_d, data_d;
  logic        start_d, op_ok, busy, cmd_wr, data_wr;

  generate
    if (OP_MODE == 0) begin : g_op2
      assign op_ok   = (wdata[CMD_OP+:2] == 2'b01) || (wdata[CMD_OP+:2] == 2'b11);
      assign c45     = cmd_q[CMD_FLAG];
      assign is_read = (cmd_q[CMD_OP+:2] == 2'b11);
    end else begin : g_op1
      assign op_ok   = 1'b1;
      assign c45     = 1'b0;
      assign is_read = !cmd_q[CMD_FLAG];
    end
  endgenerate

  always_comb begin
    busy    = cmd_q[CMD_BUSY];
    cmd_wr  = we && !busy && !sel_data && (!wdata[CMD_BUSY] || op_ok);
    data_wr = we && !busy && sel_data;
    start_d = cmd_wr && wdata[CMD_BUSY];
    cmd_d   = cmd_q;
    data_d  = data_q;
    if (cmd_wr) cmd_d = wdata;
    if (data_wr) data_d = wdata;
    if (done) begin
      cmd_d[CMD_BUSY] = 1'b0;
      if (is_read) data_d[15:0] = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      data_q  <= '0;
      start_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/mdio_csr_master.sv
module mdio_csr_master
  import mdio_pkg::*;
#(
  parameter int OP_MODE      = 0,
  parameter int DIV_MIN_LOG2 = 4,
  parameter int DIV_SEL_MAX  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_sel_data,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_cmd_rd,
  output logic [31:0] csr_data_rd,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic        rst_s1, rst_s2;
  logic        start, c45, is_read, active, rise, fall, eng_done;
  logic [15:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mdio_csr_regs #(.OP_MODE(OP_MODE)) u_regs (
    .clk(clk), .rst_n(rst_s2), .we(csr_we), .sel_data(csr_sel_data),
    .wdata(csr_wdata), .done(eng_done), .rd_word(rd_word),
    .cmd_q(csr_cmd_rd), .data_q(csr_data_rd), .start_q(start),
    .c45(c45), .is_read(is_read)
  );

  mdio_clkdiv #(.SEL_W(SEL_W), .MIN_LOG2(DIV_MIN_LOG2), .SEL_MAX(DIV_SEL_MAX)) u_div (
    .clk(clk), .rst_n(rst_s2), .run(active), .sel(csr_cmd_rd[CMD_SEL+:SEL_W]),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_s2), .start(start), .c45(c45), .is_read(is_read),
    .phy(csr_cmd_rd[CMD_PHY+:5]), .regad(csr_cmd_rd[CMD_REG+:5]),
    .payload(csr_data_rd), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(eng_done),
    .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio_csr_master_chk.sv
module mdio_csr_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        we,
  input logic        sel_data,
  input logic [31:0] cmd_q,
  input logic [31:0] data_q,
  input logic        eng_done
);
  // R9
  mdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc)));

  // R8
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[0] |-> !mdc);

  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[0] |-> !mdio_oe);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && we && sel_data && !eng_done) |=> $stable(data_q));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && $past(cmd_q[0])) |-> (cmd_q[31:1] == $past(cmd_q[31:1])));

  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[0]) |-> $past(eng_done));
endmodule

bind mdio_csr_master mdio_csr_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .we(csr_we), .sel_data(csr_sel_data), .cmd_q(csr_cmd_rd),
  .data_q(csr_data_rd), .eng_done(eng_done)
);

// File: tb/mdio_csr_master_bench.sv
module mdio_csr_master_bench;
  logic        clk, rst_n, csr_we, csr_sel, mdio_i, use_leg;
  logic [31:0] csr_wdata;
  logic [31:0] cmd_m, data_m, cmd_l, data_l;
  logic        mdc_m, mdo_m, oe_m, mdc_l, mdo_l, oe_l;
  logic        m_mdc, m_mdo, m_oe;
  logic [31:0] cur_cmd, cur_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(negedge clk) cyc++;

  mdio_csr_master u_mdio_csr_master (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we & ~use_leg), .csr_sel_data(csr_sel),
    .csr_wdata(csr_wdata), .csr_cmd_rd(cmd_m), .csr_data_rd(data_m),
    .mdc(mdc_m), .mdio_i(mdio_i), .mdio_o(mdo_m), .mdio_oe(oe_m)
  );

  mdio_csr_master #(.OP_MODE(1)) u_mdio_csr_master_leg (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we & use_leg), .csr_sel_data(csr_sel),
    .csr_wdata(csr_wdata), .csr_cmd_rd(cmd_l), .csr_data_rd(data_l),
    .mdc(mdc_l), .mdio_i(mdio_i), .mdio_o(mdo_l), .mdio_oe(oe_l)
  );

  assign m_mdc    = use_leg ? mdc_l : mdc_m;
  assign m_mdo    = use_leg ? mdo_l : mdo_m;
  assign m_oe     = use_leg ? oe_l  : oe_m;
  assign cur_cmd  = use_leg ? cmd_l : cmd_m;
  assign cur_data = use_leg ? data_l : data_m;

  typedef struct packed {
    logic [63:0] bits;
    logic [63:0] oe;
    logic [31:0] period;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  logic [63:0] cap_b, cap_oe;
  int          ridx = 0;
  int          last_rise = 0;
  bit          per_bad = 0;
  int          per_seen = 0;
  logic [15:0] resp = 16'h0;

  always @(posedge m_mdc) begin
    exp_t  e;
    string t;
    cap_b[63-ridx]  = m_mdo;
    cap_oe[63-ridx] = m_oe;
    if (ridx > 0 && expq.size() > 0 && (cyc - last_rise) != int'(expq[0].period)) begin
      per_bad  = 1'b1;
      per_seen = cyc - last_rise;
    end
    last_rise = cyc;
    if (ridx == 63) begin
      ridx = 0;
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected frame", cap_b, 64'h0);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        chk((((cap_b ^ e.bits) & e.oe) == 64'h0), {t, " frame bits"}, cap_b, e.bits);
        chk(cap_oe == e.oe, {t, " output enable"}, cap_oe, e.oe);
        chk(!per_bad, "R8 MDC period", 64'(per_seen), 64'(e.period));
      end
      per_bad = 1'b0;
    end else begin
      ridx++;
    end
  end

  // PHY model: drives read data after falling MDC edges
  always @(negedge m_mdc) begin
    if (ridx >= 48) mdio_i = resp[63-ridx];
    else mdio_i = 1'b1;
  end

  // R9: driven value must not move while MDC is high
  int   r9_bad = 0;
  logic prev_mdo, prev_oe;
  always @(negedge clk) begin
    if (m_mdc && m_oe && prev_oe && (m_mdo !== prev_mdo)) r9_bad++;
    prev_mdo = m_mdo;
    prev_oe  = m_oe;
  end

  task automatic csr_wr(input bit sel_data, input logic [31:0] w);
    @(negedge clk);
    csr_we    = 1'b1;
    csr_sel   = sel_data;
    csr_wdata = w;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    @(negedge clk);
    while (cur_cmd[0] && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 40000, {tag, " busy timeout"}, 64'(n), 64'd40000);
  endtask

  task automatic push_frame(input logic [63:0] b, input logic [63:0] o,
                            input int per, input string tag);
    exp_t e;
    e.bits   = b;
    e.oe     = o;
    e.period = 32'(per);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic txn(input bit leg, input bit c45, input bit rd, input logic [4:0] phy,
                     input logic [4:0] rg, input logic [3:0] sel, input logic [15:0] hi,
                     input logic [15:0] lo, input logic [15:0] rsp, input bit poke,
                     input string tag);
    logic [63:0] rel_mask, all_on;
    logic [31:0] cw;
    int          per;
    per      = 16 << ((sel > 4'd3) ? 3 : int'(sel));
    all_on   = '1;
    rel_mask = 64'hFFFF_FFFF_FFFC_0000;
    if (c45) begin
      push_frame({32'hFFFF_FFFF, 2'b00, 2'b00, phy, rg, 2'b10, hi}, all_on, per, tag);
      push_frame({32'hFFFF_FFFF, 2'b00, rd ? 2'b11 : 2'b01, phy, rg, 2'b10, lo},
                 rd ? rel_mask : all_on, per, tag);
    end else begin
      push_frame({32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, lo},
                 rd ? rel_mask : all_on, per, tag);
    end
    if (leg) cw = {6'b0, phy, rg, 4'b0, sel, 6'b0, !rd, 1'b1};
    else     cw = {6'b0, phy, rg, 4'b0, sel, 4'b0, rd ? 2'b11 : 2'b01, c45, 1'b1};
    resp    = rsp;
    use_leg = leg;
    csr_wr(1'b1, {hi, lo});
    csr_wr(1'b0, cw);
    @(negedge clk);
    chk(cur_cmd[0] == 1'b1, "R2 busy set after start", 64'(cur_cmd), 64'(cw));
    if (poke) begin
      repeat (50) @(negedge clk);
      csr_wr(1'b1, 32'h1234_5678);
      csr_wr(1'b0, 32'h0000_0000);
      csr_wr(1'b0, 32'hFFFF_FFFF);
    end
    wait_idle(tag);
    chk(cur_cmd == (cw & ~32'h1), {tag, " R2 R10 command after done"}, 64'(cur_cmd),
        64'(cw & ~32'h1));
    chk(cur_data == {hi, rd ? rsp : lo}, {tag, " R7 R10 data after done"},
        64'(cur_data), 64'({hi, rd ? rsp : lo}));
    chk(expq.size() == 0, {tag, " R2 all frames sent"}, 64'(expq.size()), 64'd0);
    chk(!m_mdc && !m_oe, {tag, " R8 idle pins"}, 64'({m_mdc, m_oe}), 64'd0);
  endtask

  initial begin
    rst_n     = 1'b0;
    csr_we    = 1'b0;
    csr_sel   = 1'b0;
    csr_wdata = '0;
    mdio_i    = 1'b1;
    use_leg   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(cmd_m == 32'h0 && data_m == 32'h0, "R1 registers after reset",
        64'({cmd_m, data_m}), 64'h0);
    chk(!mdc_m && !oe_m, "R1 pins after reset", 64'({mdc_m, oe_m}), 64'h0);

    // R3 clause 22 write, divide by 16
    txn(0, 0, 0, 5'h05, 5'h1A, 4'd0, 16'h0000, 16'hA55A, 16'h0, 0, "R3 c22 write");
    // R7 clause 22 read, divide by 32, upper half preserved
    txn(0, 0, 1, 5'h1F, 5'h02, 4'd1, 16'hBEEF, 16'h0000, 16'hC3E1, 0, "R7 c22 read");
    // R6 clause 45 write, divide by 64
    txn(0, 1, 0, 5'h11, 5'h03, 4'd2, 16'h0420, 16'h5AA5, 16'h0, 0, "R6 c45 write");
    // R6 clause 45 read, divide by 128
    txn(0, 1, 1, 5'h00, 5'h1E, 4'd3, 16'hFFFF, 16'h0000, 16'h8001, 0, "R6 c45 read");
    // R8 select above range clamps to divide by 128
    txn(0, 0, 0, 5'h0A, 5'h15, 4'd7, 16'h0000, 16'h0F0F, 16'h0, 0, "R8 sel clamp");

    // R4 busy write with code 10 is ignored
    csr_wr(1'b0, {6'b0, 5'h03, 5'h04, 4'b0, 4'd0, 4'b0, 2'b10, 1'b0, 1'b1});
    repeat (300) @(negedge clk);
    chk(cmd_m == 32'h0000_0700 | {6'b0, 5'h0A, 5'h15, 16'h0} ? cmd_m ==
        ({6'b0, 5'h0A, 5'h15, 4'b0, 4'd7, 4'b0, 2'b01, 1'b0, 1'b0}) : 1'b0,
        "R4 invalid code ignored", 64'(cmd_m),
        64'({6'b0, 5'h0A, 5'h15, 4'b0, 4'd7, 4'b0, 2'b01, 1'b0, 1'b0}));
    chk(!mdc_m && !oe_m, "R4 no frame for invalid code", 64'({mdc_m, oe_m}), 64'h0);
    // R4 code 00 also refused
    csr_wr(1'b0, 32'h0000_0001);
    @(negedge clk);
    chk(cmd_m[0] == 1'b0, "R4 code 00 refused", 64'(cmd_m), 64'h0);

    // R10 writes during busy are ignored
    txn(0, 0, 0, 5'h07, 5'h09, 4'd0, 16'h3C3C, 16'h6996, 16'h0, 1, "R10 busy writes");

    // R5 legacy decode: write then read
    txn(1, 0, 0, 5'h02, 5'h11, 4'd0, 16'h0000, 16'h1357, 16'h0, 0, "R5 legacy write");
    txn(1, 0, 1, 5'h1C, 5'h06, 4'd0, 16'h2468, 16'h0000, 16'h7E81, 0, "R5 legacy read");

    chk(r9_bad == 0, "R9 MDIO stable while MDC high", 64'(r9_bad), 64'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule